// File: doc/BRIEF.md
# Power-State Request Interrupt Register

This block links a host-facing register port to a core-facing register port and turns host power-state requests into core status bits and an interrupt. On the host side it holds a power-button mode bit, a power-supply-off bit and a field of sleep-state request bits S1 to S5. On the core side it holds one status bit per state request (S0 to S5), a mode-change status bit and a power-off status bit. It also holds a matching interrupt enable mask, a readback of the current mode and one interrupt output.

Both ports use a plain single-cycle register bus. A write takes effect at the clock edge where the write strobe is high. Read data is registered: it reflects the address and the state present at the edge, and it is valid after that edge. Writing zero to the whole sleep field is a request for S0. Core software clears a pending request in one of two ways: it writes 1 to the status bit, or it clears the enable bit. Acting on the requests is left to the core.

Top module: `pwr_req_irq`

## Requirements
- R1: After reset every status bit, enable bit, host register, read data bus and the interrupt output are 0.
- R2: A host read of address 0 returns the last written mode in bit 0 and the power-off bit in bit 1. A host read of address 1 returns the last written S1..S5 field in bits 4:0, with S1 in bit 0. Unused addresses read 0.
- R3: A host write to address 0 whose bit 0 differs from the stored mode sets core status bit 6 (mode change). A write with the same mode does not set it. Core address 2 returns the current mode in bit 0.
- R4: A host write to address 0 with bit 1 at 1 sets core status bit 7 (power off). The same write with bit 1 at 0 does not set it.
- R5: A host write to address 1 with bit k at 1 (k = 0..4) sets core status bit k+1 (S(k+1)).
- R6: A host write to address 1 with bits 4:0 all 0 sets core status bit 0 (S0).
- R7: A core write to address 0 clears each status bit written with 1. Status bits written with 0 keep their value.
- R8: A core write to address 1 (enable mask, same bit positions as status) loads the enable bits. Any bit written 0 also clears its status bit. Core address 1 reads the enable bits back.
- R9: When a host set and a core clear (by write-1 or by masking) hit the same status bit in one cycle, the bit ends set.
- R10: The interrupt output is the registered OR of all (status AND enable) pairs. It follows them one clock later. A status bit set while its enable is 0 does not drive the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | AW | Host register address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, registered |
| c_wr | input | 1 | Core write strobe |
| c_addr | input | AW | Core register address |
| c_wdata | input | DW | Core write data |
| c_rdata | output | DW | Core read data, registered |
| irq | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach is a collision on one status bit. It happens when the host request that sets the bit lands in the same cycle as a core write-1-to-clear or an enable write that masks the same bit. The bench drives both buses in the same cycle. Directed steps aim the two writes at S1. The random phase drives both ports independently every cycle, so the collision recurs against many different mask and status states. Sleep-field writes are biased towards all zeros so that the S0 decode gets hit often.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
  // host-side register map
  localparam int HA_CFG    = 0;
  localparam int HA_SLP    = 1;
  localparam int CFG_MODE  = 0;
  localparam int CFG_POFF  = 1;
  // core-side register map
  localparam int CA_STAT   = 0;
  localparam int CA_EN     = 1;
  localparam int CA_MODE   = 2;

  // event index helpers: S0..Sn first, then mode change, then power off
  function automatic int ev_mode(input int nslp);
    return nslp + 1;
  endfunction

  function automatic int ev_poff(input int nslp);
    return nslp + 2;
  endfunction
endpackage

// File: rtl/pwr_host_side.sv
module pwr_host_side
  import pwr_req_pkg::*;
#(
  parameter int NSLP = 5,
  parameter int DW   = 8,
  parameter int AW   = 2,
  localparam int NEV = NSLP + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wr,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          mode_o,
  output logic [NEV-1:0] set_o
);
  logic            mode_q;
  logic            poff_q;
  logic [NSLP-1:0] slp_q;
  logic            cfg_wr;
  logic            slp_wr;

  assign cfg_wr = h_wr && (h_addr == AW'(HA_CFG));
  assign slp_wr = h_wr && (h_addr == AW'(HA_SLP));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      poff_q <= 1'b0;
      slp_q  <= '0;
    end else begin
      if (cfg_wr) begin
        mode_q <= h_wdata[CFG_MODE];
        poff_q <= h_wdata[CFG_POFF];
      end
      if (slp_wr) slp_q <= h_wdata[NSLP-1:0];
    end
  end

  // request pulses toward the core status bank
  assign set_o[0] = slp_wr && (h_wdata[NSLP-1:0] == '0);
  for (genvar k = 0; k < NSLP; k++) begin : g_slp
    assign set_o[k+1] = slp_wr && h_wdata[k];
  end
  assign set_o[ev_mode(NSLP)] = cfg_wr && (h_wdata[CFG_MODE] != mode_q);
  assign set_o[ev_poff(NSLP)] = cfg_wr && h_wdata[CFG_POFF];

  logic [DW-1:0] rd_n;
  always_comb begin
    rd_n = '0;
    if (h_addr == AW'(HA_CFG)) begin
      rd_n[CFG_MODE] = mode_q;
      rd_n[CFG_POFF] = poff_q;
    end else if (h_addr == AW'(HA_SLP)) begin
      rd_n[NSLP-1:0] = slp_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) h_rdata <= '0;
    else     h_rdata <= rd_n;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_evt_cell.sv
module pwr_evt_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_val_i,
  output logic st_o,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_o <= 1'b0;
      en_o <= 1'b0;
    end else begin
      if (en_wr_i) en_o <= en_val_i;
      if (set_i)      st_o <= 1'b1;   // host request wins over any clear
      else if (clr_i) st_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_req_irq.sv
module pwr_req_irq
  import pwr_req_pkg::*;
#(
  parameter int NSLP = 5,
  parameter int DW   = 8,
  parameter int AW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wr,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          c_wr,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic          irq
);
  localparam int NEV = NSLP + 3;

  logic [NEV-1:0] set_v;
  logic [NEV-1:0] clr_v;
  logic [NEV-1:0] stat_v;
  logic [NEV-1:0] en_v;
  logic           mode;
  logic           stat_wr;
  logic           en_wr;

  pwr_host_side #(.NSLP(NSLP), .DW(DW), .AW(AW)) host_i (
    .clk     (clk),
    .rst     (rst),
    .h_wr    (h_wr),
    .h_addr  (h_addr),
    .h_wdata (h_wdata),
    .h_rdata (h_rdata),
    .mode_o  (mode),
    .set_o   (set_v)
  );

  assign stat_wr = c_wr && (c_addr == AW'(CA_STAT));
  assign en_wr   = c_wr && (c_addr == AW'(CA_EN));

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    assign clr_v[i] = (stat_wr && c_wdata[i]) || (en_wr && !c_wdata[i]);
    pwr_evt_cell cell_i (
      .clk      (clk),
      .rst      (rst),
      .set_i    (set_v[i]),
      .clr_i    (clr_v[i]),
      .en_wr_i  (en_wr),
      .en_val_i (c_wdata[i]),
      .st_o     (stat_v[i]),
      .en_o     (en_v[i])
    );
  end

  logic [DW-1:0] crd_n;
  always_comb begin
    crd_n = '0;
    if (c_addr == AW'(CA_STAT))      crd_n[NEV-1:0] = stat_v;
    else if (c_addr == AW'(CA_EN))   crd_n[NEV-1:0] = en_v;
    else if (c_addr == AW'(CA_MODE)) crd_n[0]       = mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_rdata <= '0;
      irq     <= 1'b0;
    end else begin
      c_rdata <= crd_n;
      irq     <= |(stat_v & en_v);
    end
  end
endmodule

// File: rtl/pwr_req_irq_chk.sv
module pwr_req_irq_chk #(
  parameter int NEV = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           irq,
  input logic [NEV-1:0] set_v,
  input logic [NEV-1:0] clr_v,
  input logic [NEV-1:0] stat_v,
  input logic [NEV-1:0] en_v
);
  p_irq_on_r10: assert property (@(posedge clk) disable iff (rst)
    (|(stat_v & en_v)) |=> irq);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_v & en_v)) |=> !irq);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((stat_v & $past(set_v)) == $past(set_v)));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ((clr_v & ~set_v) != '0) |=> ((stat_v & $past(clr_v & ~set_v)) == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((set_v == '0) && (clr_v == '0)) |=> $stable(stat_v));
endmodule

bind pwr_req_irq pwr_req_irq_chk #(.NEV(NSLP + 3)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .set_v  (set_v),
  .clr_v  (clr_v),
  .stat_v (stat_v),
  .en_v   (en_v)
);

// File: tb/pwr_req_irq_tb_top.sv
module pwr_req_irq_tb_top;
  localparam int NSLP = 5;
  localparam int DW   = 8;
  localparam int AW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          h_wr = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic [DW-1:0] h_rdata;
  logic          c_wr = 1'b0;
  logic [AW-1:0] c_addr = '0;
  logic [DW-1:0] c_wdata = '0;
  logic [DW-1:0] c_rdata;
  logic          irq;

  always #2 clk = ~clk;

  pwr_req_irq #(.NSLP(NSLP), .DW(DW), .AW(AW)) dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model of the visible state
  logic       m_mode = 0, m_poff = 0;
  logic [4:0] m_slp  = 0;
  logic [7:0] m_stat = 0, m_en = 0;

  function automatic logic [7:0] h_exp(input logic [1:0] a);
    if (a == 2'd0) return {6'b0, m_poff, m_mode};
    if (a == 2'd1) return {3'b0, m_slp};
    return 8'h00;
  endfunction

  function automatic logic [7:0] c_exp(input logic [1:0] a);
    if (a == 2'd0) return m_stat;
    if (a == 2'd1) return m_en;
    if (a == 2'd2) return {7'b0, m_mode};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one clock: drive both ports, update model, compare registered outputs
  task automatic step(input string tag,
                      input logic hw, input logic [1:0] ha, input logic [7:0] hd,
                      input logic cw, input logic [1:0] ca, input logic [7:0] cd);
    logic [7:0] eh, ec, set, clr;
    logic       ei;
    @(negedge clk);
    h_wr = hw; h_addr = ha; h_wdata = hd;
    c_wr = cw; c_addr = ca; c_wdata = cd;
    eh  = h_exp(ha);
    ec  = c_exp(ca);
    ei  = |(m_stat & m_en);
    set = 8'h00;
    clr = 8'h00;
    if (hw && ha == 2'd0) begin
      set[6] = (hd[0] != m_mode);                  // R3
      set[7] = hd[1];                              // R4
      m_mode = hd[0];
      m_poff = hd[1];
    end
    if (hw && ha == 2'd1) begin
      set[5:1] = hd[4:0];                          // R5
      set[0]   = (hd[4:0] == 5'd0);                // R6
      m_slp    = hd[4:0];
    end
    if (cw && ca == 2'd0) clr = hd_or(cd);         // R7
    if (cw && ca == 2'd1) begin
      clr  = ~cd;                                  // R8
      m_en = cd;
    end
    m_stat = (m_stat & ~clr) | set;                // R9: set wins
    @(posedge clk);
    #1;
    chk({tag, " h_rdata"}, h_rdata, eh);
    chk({tag, " c_rdata"}, c_rdata, ec);
    chk({tag, " irq"}, {7'b0, irq}, {7'b0, ei});
  endtask

  function automatic logic [7:0] hd_or(input logic [7:0] d);
    return d;
  endfunction

  task automatic idle(input string tag, input logic [1:0] ha, input logic [1:0] ca);
    step(tag, 1'b0, ha, 8'h00, 1'b0, ca, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 c_rdata", c_rdata, 8'h00);
    idle("R1 stat", 2'd0, 2'd0);
    idle("R1 en", 2'd1, 2'd1);
    // R3 R4: mode 0->1 with power-off request
    step("R3 wr", 1'b1, 2'd0, 8'h03, 1'b0, 2'd0, 8'h00);
    idle("R2 cfg rd", 2'd0, 2'd2);
    idle("R3 mode rd", 2'd0, 2'd2);
    idle("R4 stat", 2'd0, 2'd0);
    chk("R3 R4 stat bits", c_rdata, 8'hC0);
    // R7: clear both by write-1, then same mode with poff 0 sets nothing
    step("R7 w1c", 1'b0, 2'd0, 8'h00, 1'b1, 2'd0, 8'hC0);
    step("R3 same mode", 1'b1, 2'd0, 8'h01, 1'b0, 2'd0, 8'h00);
    idle("R4 no poff", 2'd0, 2'd0);
    chk("R3 R4 nothing set", c_rdata, 8'h00);
    // R5 then R6
    step("R5 slp", 1'b1, 2'd1, 8'h15, 1'b0, 2'd0, 8'h00);
    idle("R5 stat", 2'd1, 2'd0);
    chk("R5 stat bits", c_rdata, 8'h2A);
    chk("R2 slp rd", h_rdata, 8'h15);
    step("R6 zero", 1'b1, 2'd1, 8'hE0, 1'b0, 2'd0, 8'h00);
    idle("R6 stat", 2'd1, 2'd0);
    chk("R6 S0 bit", c_rdata, 8'h2B);
    // R7: write-1 clears only the written bits
    step("R7 part", 1'b0, 2'd0, 8'h00, 1'b1, 2'd0, 8'h0A);
    idle("R7 stat", 2'd0, 2'd0);
    chk("R7 remaining", c_rdata, 8'h21);
    // R10: pending with enable 0 gives no irq, then enable raises it
    chk("R10 masked", {7'b0, irq}, 8'h00);
    step("R10 en", 1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 8'h21);
    idle("R10 lag", 2'd0, 2'd1);
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    // R8: masking bit 5 clears its status
    step("R8 mask", 1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 8'h01);
    idle("R8 stat", 2'd0, 2'd0);
    chk("R8 cleared", c_rdata, 8'h01);
    // R9: host sets S1 while core clears bit 1 by write-1, then by mask
    step("R9 w1c", 1'b1, 2'd1, 8'h01, 1'b1, 2'd0, 8'h02);
    idle("R9 stat", 2'd0, 2'd0);
    chk("R9 set wins w1c", c_rdata & 8'h02, 8'h02);
    step("R9 mask", 1'b1, 2'd1, 8'h01, 1'b1, 2'd1, 8'h00);
    idle("R9 stat2", 2'd0, 2'd0);
    chk("R9 set wins mask", c_rdata & 8'h02, 8'h02);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] hd;
      logic [1:0] ha, ca;
      ha = 2'($urandom_range(0, 3));
      ca = 2'($urandom_range(0, 3));
      hd = 8'($urandom);
      if (ha == 2'd1 && $urandom_range(0, 3) == 0) hd = 8'h00;
      step("RND R2-R10", 1'($urandom_range(0, 1)), ha, hd,
           ($urandom_range(0, 2) == 0), ca, 8'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule